// File: doc/BRIEF.md
# Periodic Interrupt And Halt Controller

This controller paces a processor core with an instruction-counted timer. A down-counter is loaded with a programmable period and moves one step for every retired instruction. A step taken while the count sits at zero reloads the counter and, when synchronous generation is enabled, latches an interrupt request. In the following cycle the request is offered to the core. It is taken, with a push-PC request and a jump target, only if interrupts are enabled and the external vector is valid. In every other case it is thrown away.

The target address depends on the vector mode. In vector-base mode it is the 8-bit base register in the high byte with all ones in the low byte. Otherwise it is the externally supplied vector. A halt instruction that retires while the count is nonzero parks the core: the counter then steps by itself on every clock until it reaches zero. At that point the halt ends, the interrupt enable is asked to be set, and the counter reloads. A 2-bit status field mirrors counter bits 6:5.

Top module: `irq_halt_ctl`

## Requirements
- R1: After synchronous reset the counter holds the default period (200 in the test configuration, so stat_o reads 2), halted_o is 0 and take_o is 0.
- R2: Each step decrements the counter by one. A step is retire_i, halt_i, or any cycle while halted_o is 1. In a cycle without a step the counter does not change. stat_o always shows counter bits 6:5.
- R3: A step taken while the count is zero reloads the period, so with period P a request is produced once every P+1 steps. The request is presented in the cycle after that step.
- R4: A presented request gives take_o = push_o = 1 for exactly that one cycle, if ie_i = 1 and ext_vld_i = 1. Otherwise it is discarded and is not offered again.
- R5: On a take, target_o is {vec_base_i, 8'hFF} when vec_mode_i = 1, and ext_vec_i when vec_mode_i = 0.
- R6: A period write does not alter the running count. It is used at the next reload, and a write in the same cycle as a reload takes effect only at the reload after that one.
- R7: A halt_i with a nonzero count sets halted_o from the next cycle on. While halted_o is 1 the counter steps every cycle.
- R8: set_ie_o is 1 in a cycle where the count is zero and either halted_o or halt_i is 1. A halt_i at a zero count therefore does not halt. halted_o drops in the cycle after set_ie_o.
- R9: With sync_i = 0, a step at zero still reloads the counter but latches no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retired this cycle |
| halt_i | input | 1 | A halt instruction retired this cycle |
| sync_i | input | 1 | Latch a request when the count expires |
| ie_i | input | 1 | Interrupt enable |
| vec_mode_i | input | 1 | 1: target from vector base, 0: external vector |
| vec_base_i | input | 8 | Vector base register, high byte of the target |
| ext_vec_i | input | 16 | External interrupt vector |
| ext_vld_i | input | 1 | External vector is valid |
| per_wr_i | input | 1 | Write per_data_i into the period register |
| per_data_i | input | 16 | New period value |
| take_o | output | 1 | Interrupt taken this cycle |
| push_o | output | 1 | Push the current PC this cycle |
| target_o | output | 16 | Interrupt target address |
| halted_o | output | 1 | Core is parked by a halt |
| set_ie_o | output | 1 | Set the interrupt enable (halt release) |
| stat_o | output | 2 | Counter bits 6:5 |

## Verification
The counter and stat_o move on the clock edge that ends a step cycle. take_o, push_o and target_o belong to the cycle after a zero-count step. set_ie_o is combinational in the zero cycle itself, and halted_o changes one edge after the halt_i or set_ie_o cycle that causes it. The bench drives each cycle's inputs at the falling edge and samples the outputs 1 ns later, before the rising edge. It compares them against a step model that it advances only after that edge, so every expectation belongs to the cycle in which it is due. Sweeps over small periods, gapped retire patterns, both vector modes and halts that start at zero and at nonzero counts exercise the reload spacing and the release timing.

// File: rtl/irq_halt_pkg.sv
package irq_halt_pkg;
   typedef enum logic {
      HS_RUN  = 1'b0,
      HS_PARK = 1'b1
   } halt_state_e;
endpackage

// File: rtl/irq_tick_counter.sv
module irq_tick_counter #(
   parameter int CNT_W          = 16,
   parameter int DEFAULT_PERIOD = 10000
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_i,
   input  logic             sync_i,
   input  logic             per_wr_i,
   input  logic [CNT_W-1:0] per_data_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] per_o,
   output logic             zero_o,
   output logic             req_o
);
   localparam logic [CNT_W-1:0] RST_PER = CNT_W'(DEFAULT_PERIOD);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic             req_q;

   assign zero_o = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= RST_PER;
         per_q <= RST_PER;
         req_q <= 1'b0;
      end else begin
         // request lives for one cycle: consumed whether taken or not
         req_q <= step_i & zero_o & sync_i;
         if (step_i) begin
            cnt_q <= zero_o ? per_q : cnt_q - 1'b1;
         end
         if (per_wr_i) begin
            per_q <= per_data_i;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign per_o = per_q;
   assign req_o = req_q;
endmodule

// File: rtl/irq_vector_sel.sv
module irq_vector_sel #(
   parameter int VEC_W   = 16,
   parameter bit MODE_EN = 1'b1
) (
   input  logic [VEC_W/2-1:0] base_i,
   input  logic [VEC_W-1:0]   ext_i,
   input  logic               mode_i,
   output logic [VEC_W-1:0]   target_o
);
   localparam int HALF_W = VEC_W / 2;

   generate
      if (MODE_EN) begin : g_base_mode
         assign target_o = mode_i ? {base_i, {HALF_W{1'b1}}} : ext_i;
      end else begin : g_ext_only
         logic unused_sel;
         assign unused_sel = &{1'b0, base_i, mode_i};
         assign target_o   = ext_i;
      end
   endgenerate
endmodule

// File: rtl/irq_halt_fsm.sv
module irq_halt_fsm
   import irq_halt_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic halt_i,
   input  logic zero_i,
   output logic halted_o,
   output logic release_o
);
   halt_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         HS_RUN:  if (halt_i && !zero_i) st_d = HS_PARK;
         HS_PARK: if (zero_i)            st_d = HS_RUN;
         default: st_d = HS_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= HS_RUN;
      else     st_q <= st_d;
   end

   assign halted_o  = (st_q == HS_PARK);
   assign release_o = (halted_o | halt_i) & zero_i;
endmodule

// File: rtl/irq_halt_ctl.sv
module irq_halt_ctl #(
   parameter int CNT_W          = 16,
   parameter int DEFAULT_PERIOD = 10000,
   parameter int VEC_W          = 16,
   parameter int STAT_LO        = 5,
   parameter int STAT_W         = 2,
   parameter bit MODE_EN        = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               retire_i,
   input  logic               halt_i,
   input  logic               sync_i,
   input  logic               ie_i,
   input  logic               vec_mode_i,
   input  logic [VEC_W/2-1:0] vec_base_i,
   input  logic [VEC_W-1:0]   ext_vec_i,
   input  logic               ext_vld_i,
   input  logic               per_wr_i,
   input  logic [CNT_W-1:0]   per_data_i,
   output logic               take_o,
   output logic               push_o,
   output logic [VEC_W-1:0]   target_o,
   output logic               halted_o,
   output logic               set_ie_o,
   output logic [STAT_W-1:0]  stat_o
);
   generate
      if (CNT_W < STAT_LO + STAT_W) begin : g_bad_stat
         $error("status field lies outside the counter");
      end
      if (CNT_W < 31 && DEFAULT_PERIOD >= (1 << CNT_W)) begin : g_bad_per
         $error("default period does not fit the counter");
      end
      if (VEC_W % 2 != 0) begin : g_bad_vec
         $error("vector width must be even");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] per_w;
   logic             zero_w;
   logic             req_w;
   logic             step_w;

   assign step_w = retire_i | halt_i | halted_o;

   irq_tick_counter #(
      .CNT_W         (CNT_W),
      .DEFAULT_PERIOD(DEFAULT_PERIOD)
   ) cnt_i (
      .clk       (clk),
      .rst       (rst),
      .step_i    (step_w),
      .sync_i    (sync_i),
      .per_wr_i  (per_wr_i),
      .per_data_i(per_data_i),
      .cnt_o     (cnt_w),
      .per_o     (per_w),
      .zero_o    (zero_w),
      .req_o     (req_w)
   );

   irq_vector_sel #(
      .VEC_W  (VEC_W),
      .MODE_EN(MODE_EN)
   ) vsel_i (
      .base_i  (vec_base_i),
      .ext_i   (ext_vec_i),
      .mode_i  (vec_mode_i),
      .target_o(target_o)
   );

   irq_halt_fsm hfsm_i (
      .clk      (clk),
      .rst      (rst),
      .halt_i   (halt_i),
      .zero_i   (zero_w),
      .halted_o (halted_o),
      .release_o(set_ie_o)
   );

   assign take_o = req_w & ie_i & ext_vld_i;
   assign push_o = take_o;
   assign stat_o = cnt_w[STAT_LO +: STAT_W];
endmodule

// File: rtl/irq_halt_ctl_chk.sv
module irq_halt_ctl_chk #(
   parameter int CNT_W   = 16,
   parameter int VEC_W   = 16,
   parameter bit MODE_EN = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             step_w,
   input logic             zero_w,
   input logic [CNT_W-1:0] cnt_w,
   input logic [CNT_W-1:0] per_w,
   input logic             halt_i,
   input logic             halted_o,
   input logic             set_ie_o,
   input logic             take_o,
   input logic             vec_mode_i,
   input logic [VEC_W-1:0] target_o
);
   // R2
   step_dec_chk: assert property (@(posedge clk) disable iff (rst)
      step_w && !zero_w |=> cnt_w == $past(cnt_w) - 1'b1);

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !step_w |=> $stable(cnt_w));

   // R3
   reload_chk: assert property (@(posedge clk) disable iff (rst)
      step_w && zero_w |=> cnt_w == $past(per_w));

   // R4
   take_origin_chk: assert property (@(posedge clk) disable iff (rst)
      take_o |-> $past(step_w && zero_w));

   // R7
   park_chk: assert property (@(posedge clk) disable iff (rst)
      halt_i && !halted_o && !zero_w |=> halted_o);

   // R8
   release_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(halted_o) |-> $past(set_ie_o));

   generate
      if (MODE_EN) begin : g_mode_chk
         // R5
         base_low_chk: assert property (@(posedge clk) disable iff (rst)
            take_o && vec_mode_i |-> &target_o[VEC_W/2-1:0]);
      end
   endgenerate
endmodule

bind irq_halt_ctl irq_halt_ctl_chk #(
   .CNT_W  (CNT_W),
   .VEC_W  (VEC_W),
   .MODE_EN(MODE_EN)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .step_w    (step_w),
   .zero_w    (zero_w),
   .cnt_w     (cnt_w),
   .per_w     (per_w),
   .halt_i    (halt_i),
   .halted_o  (halted_o),
   .set_ie_o  (set_ie_o),
   .take_o    (take_o),
   .vec_mode_i(vec_mode_i),
   .target_o  (target_o)
);

// File: tb/irq_halt_ctl_tb_top.sv
module irq_halt_ctl_tb_top;
   localparam int PER0 = 200;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst, retire, halt, sync, ie, vmode, vld, pwr;
   logic [7:0]  vbase;
   logic [15:0] evec, pdata;
   logic        take, push, halted, set_ie;
   logic [15:0] target;
   logic [1:0]  stat;

   irq_halt_ctl #(.DEFAULT_PERIOD(PER0)) dut_i (
      .clk(clk), .rst(rst), .retire_i(retire), .halt_i(halt), .sync_i(sync),
      .ie_i(ie), .vec_mode_i(vmode), .vec_base_i(vbase), .ext_vec_i(evec),
      .ext_vld_i(vld), .per_wr_i(pwr), .per_data_i(pdata), .take_o(take),
      .push_o(push), .target_o(target), .halted_o(halted), .set_ie_o(set_ie),
      .stat_o(stat)
   );

   int n_run = 0, n_fail = 0, n_take = 0, n_rel = 0;
   int m_cnt, m_per;
   bit m_req, m_halt, done = 1'b0;

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit r, input bit h, input bit w, input int d);
      bit exp_take, exp_rel, stp;
      @(negedge clk);
      retire = r; halt = h; pwr = w; pdata = d[15:0];
      #1;
      chk("R2 stat", int'(stat), (m_cnt >> 5) & 3);
      exp_take = m_req && ie && vld;
      chk("R4 take", int'(take), int'(exp_take));
      chk("R4 push", int'(push), int'(exp_take));
      if (exp_take) begin
         n_take++;
         chk("R5 target", int'(target), vmode ? int'({vbase, 8'hFF}) : int'(evec));
      end
      chk("R7 halted", int'(halted), int'(m_halt));
      exp_rel = (m_halt || h) && (m_cnt == 0);
      chk("R8 set_ie", int'(set_ie), int'(exp_rel));
      if (exp_rel) n_rel++;
      @(posedge clk);
      stp   = r || h || m_halt;
      m_req = stp && (m_cnt == 0) && sync;
      if (stp) begin
         if (m_cnt == 0) begin
            m_cnt  = m_per;
            m_halt = 1'b0;
         end else begin
            m_cnt--;
            if (h) m_halt = 1'b1;
         end
      end
      if (w) m_per = d & 16'hFFFF;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired, run incomplete");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int t0;
      rst = 1'b1; retire = 0; halt = 0; sync = 1; ie = 1; vmode = 0; vld = 1;
      pwr = 0; vbase = 8'hA5; evec = 16'h1234; pdata = '0;
      m_cnt = PER0; m_per = PER0; m_req = 0; m_halt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      #1;
      // R1 reset state
      chk("R1 stat after reset", int'(stat), 2);
      chk("R1 halted after reset", int'(halted), 0);
      chk("R1 take after reset", int'(take), 0);

      // R3: first request only after PER0+1 steps
      for (int k = 0; k < PER0; k++) cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
      chk("R3 no request before expiry", n_take, 0);
      cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
      chk("R3 request after period+1 steps", n_take, 1);
      repeat (5) cyc(0, 0, 0, 0);
      chk("R4 request not repeated", n_take, 1);

      // R6: new period waits for the next reload
      vmode = 1;
      cyc(0, 0, 1, 3);
      t0 = n_take;
      for (int k = 0; k < PER0; k++) cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
      chk("R6 running count kept", n_take - t0, 0);
      cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
      for (int k = 0; k < 8; k++) cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
      chk("R6 new period spacing", n_take - t0, 3);

      // R9: sync off, no requests
      sync = 0; t0 = n_take;
      for (int k = 0; k < 20; k++) cyc(1, 0, 0, 0);
      cyc(0, 0, 0, 0);
      chk("R9 no request without sync", n_take - t0, 0);
      sync = 1;

      // R4: enable or valid low discards
      ie = 0;
      for (int k = 0; k < 12; k++) cyc(1, 0, 0, 0);
      ie = 1; vld = 0;
      for (int k = 0; k < 12; k++) cyc(1, 0, 0, 0);
      vld = 1;

      // sweep periods, gapped retire, both modes
      for (int p = 0; p < 16; p++) begin
         vmode = p[0];
         evec  = 16'h4000 + 16'(p * 37);
         vbase = 8'(p * 11);
         cyc(0, 0, 1, p);
         for (int k = 0; k < 3 * (p + 1) + 4; k++) cyc(k % 3 != 1, 0, 0, 0);
      end

      // R7/R8: halt at nonzero count, then halt at zero
      cyc(0, 0, 1, 6);
      for (int k = 0; k < 8; k++) cyc(1, 0, 0, 0);
      t0 = n_rel;
      cyc(0, 1, 0, 0);
      for (int k = 0; k < 10; k++) cyc(0, 0, 0, 0);
      chk("R8 one release after halt", n_rel - t0, 1);
      cyc(0, 0, 1, 0);
      for (int k = 0; k < 12; k++) cyc(1, 0, 0, 0);
      t0 = n_rel;
      cyc(0, 1, 0, 0);
      cyc(0, 0, 0, 0);
      chk("R8 halt at zero releases at once", n_rel - t0, 1);
      chk("R7 halt at zero does not park", int'(halted), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule